// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames into memory that software owns. Frames arrive one byte per beat on a byte stream that carries the frame check sequence. Flags for a bad checksum and a short frame come with the final byte. At the start of each frame the block reads the status word of the current descriptor. If hardware owns that descriptor, the block reads the buffer pointer from descriptor offset 8. It then packs the frame bytes little-endian into 32-bit word writes with byte strobes. Last, it writes the status word back with the ownership bit cleared, which returns the descriptor to software.

Each descriptor is 16 bytes. Offset 0 holds the status word: bit 31 means owned by hardware, bit 30 marks the end of the ring, bits 29 and 28 mark the first and last segment, and bits 12:0 hold a length. Software arms a descriptor by writing the buffer capacity into bits 12:0 and setting bit 31. The ring base is set in units of 256 bytes. The block walks the descriptors 16 bytes apart and returns to the base after the descriptor that carries bit 30. A frame that finds a software-owned descriptor is consumed without touching memory, and a saturating lost-frame counter records it.

Memory is reached through a simple synchronous port. A read returns its data in the cycle after the request is sampled.

Top module: `rxring_writer`

## Requirements
- R1: After synchronous reset, in_ready, mem_req and rx_event are 0 and missed_count is 0.
- R2: For an armed descriptor (status bit 31 set), frame byte k is written to address B+k, where B is the word at descriptor offset 8. Byte k lands in lane k mod 4 (bits 8*lane+7:8*lane) of the word at B+4*floor(k/4), and only the strobed lanes change.
- R3: The status write-back clears bit 31, keeps bit 30 as software wrote it, and sets bits 29 and 28. Bits 12:0 carry the number of frame bytes, including the 4 checksum bytes.
- R4: In the write-back, bit 19 reports a checksum error and bit 20 a runt frame, both taken from the flags on the final byte. Bit 22 reports an over-long frame. Bit 21 is set exactly when any of bits 19, 20 or 22 is set. All other status bits are 0.
- R5: A frame longer than the capacity C (status bits 12:0 at hand-over) has only bytes 0..C-1 stored. Its write-back length is C, with bits 22 and 21 set.
- R6: After each write-back the current descriptor moves 16 bytes forward, or back to the ring base when the finished descriptor had bit 30 set.
- R7: A pulse on base_we sets the ring base to {ring_base_hi, 8'h00} and makes it the current descriptor.
- R8: A frame whose descriptor has bit 31 clear is consumed with no memory write and no rx_event, and missed_count rises by one. The current descriptor stays the same.
- R9: missed_count saturates at its all-ones value, and missed_clr sets it to 0.
- R10: At write-back, rx_event pulses for one cycle: 2'b01 when bit 21 is clear, 2'b10 when it is set.
- R11: The status write is the last memory write of a frame and comes after every data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load ring base and restart at it |
| ring_base_hi | input | 24 | Ring base address bits 31:8 |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of frame |
| in_crc_err | input | 1 | Checksum error, valid with in_last |
| in_runt | input | 1 | Runt frame, valid with in_last |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte strobes for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| missed_clr | input | 1 | Clear the lost-frame counter |
| missed_count | output | MISS_W | Lost-frame counter |
| rx_event | output | 2 | bit 0 good frame, bit 1 errored frame |

## Verification
Assertions check several properties on every cycle. rx_event never has both bits set, and no memory request goes out while a dropped frame is drained. The descriptor pointer returns to the base after a wrap and follows every base load. The lost-frame counter stays at its ceiling and obeys clear. Other behaviour can only be shown by the bench's scenarios, which read back memory after each frame. That covers byte packing and strobe masking, the contents of the status word, truncation at the capacity, and the status write landing after the data. The bench sweeps frame lengths across the capacity with rotating error flags, exercises drops and counter saturation, and reprograms the base.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int LEN_W      = 13;
  localparam int DESC_BYTES = 16;
  localparam int BUFPTR_OFF = 8;

  localparam int B_OWN   = 31;
  localparam int B_EOR   = 30;
  localparam int B_FS    = 29;
  localparam int B_LS    = 28;
  localparam int B_LONG  = 22;
  localparam int B_SUM   = 21;
  localparam int B_RUNT  = 20;
  localparam int B_CRC   = 19;

  typedef enum logic [2:0] {
    S_IDLE, S_ST_REQ, S_ST_CAP, S_BUF_REQ, S_BUF_CAP, S_DATA, S_WB, S_DROP
  } wr_state_t;

  function automatic logic [31:0] wb_word(input logic eor, input logic too_long,
                                          input logic runt, input logic crc,
                                          input logic [LEN_W-1:0] len);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0] = len;
    w[B_EOR]  = eor;
    w[B_FS]   = 1'b1;
    w[B_LS]   = 1'b1;
    w[B_LONG] = too_long;
    w[B_RUNT] = runt;
    w[B_CRC]  = crc;
    w[B_SUM]  = too_long | runt | crc;
    return w;
  endfunction
endpackage

// File: rtl/rxring_packer.sv
module rxring_packer
  import rxring_pkg::*;
#(
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             accept,
  input  logic [7:0]       in_byte,
  input  logic             last,
  input  logic [31:0]      buf_base,
  input  logic [LEN_W-1:0] buf_size,
  output logic             emit,
  output logic [31:0]      emit_addr,
  output logic [31:0]      emit_data,
  output logic [3:0]       emit_be,
  output logic [LEN_W-1:0] len_field,
  output logic             too_long
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      word_q;
  logic [1:0]       lane;
  logic             store;
  logic [CNT_W-1:0] size_ext;

  assign size_ext = {{(CNT_W-LEN_W){1'b0}}, buf_size};
  assign lane     = cnt_q[1:0];
  assign store    = cnt_q < size_ext;

  always_comb begin
    emit_data = word_q;
    emit_data[{lane, 3'b000} +: 8] = in_byte;
  end

  always_comb begin
    case (lane)
      2'd0:    emit_be = 4'b0001;
      2'd1:    emit_be = 4'b0011;
      2'd2:    emit_be = 4'b0111;
      default: emit_be = 4'b1111;
    endcase
  end

  assign emit      = accept && store && (lane == 2'd3 || last || cnt_q == size_ext - 1'b1);
  assign emit_addr = buf_base + 32'({cnt_q[CNT_W-1:2], 2'b00});
  assign too_long  = cnt_q > size_ext;
  assign len_field = too_long ? buf_size : cnt_q[LEN_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (accept) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (store) word_q <= emit_data;
    end
  end
endmodule

// File: rtl/rxring_ptr.sv
module rxring_ptr
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        base_we,
  input  logic [23:0] ring_base_hi,
  input  logic        advance,
  input  logic        wrap,
  output logic [31:0] cur_desc
);
  logic [31:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      cur_desc <= '0;
    end else if (base_we) begin
      base_q   <= {ring_base_hi, 8'h00};
      cur_desc <= {ring_base_hi, 8'h00};
    end else if (advance) begin
      cur_desc <= wrap ? base_q : cur_desc + 32'(DESC_BYTES);
    end
  end

  a_r6_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
    (advance && wrap) |=> (cur_desc == base_q));
  a_r7_base_load: assert property (@(posedge clk) disable iff (rst)
    base_we |=> (cur_desc == {$past(ring_base_hi), 8'h00}));
endmodule

// File: rtl/rxring_miss_ctr.sv
module rxring_miss_ctr #(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              clr,
  output logic [MISS_W-1:0] count
);
  localparam logic [MISS_W-1:0] TOP = {MISS_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)                count <= '0;
    else if (inc && count != TOP)  count <= count + 1'b1;
  end

  a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !clr) |=> (count == TOP));
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [23:0]       ring_base_hi,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              in_crc_err,
  input  logic              in_runt,
  output logic              in_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              missed_clr,
  output logic [MISS_W-1:0] missed_count,
  output logic [1:0]        rx_event
);
  wr_state_t        state;
  logic             eor_q, crc_q, runt_q;
  logic [LEN_W-1:0] size_q;
  logic [31:0]      buf_q;
  logic [31:0]      cur_desc;
  logic             pk_start, pk_accept, pk_emit, pk_long;
  logic [31:0]      pk_addr, pk_data;
  logic [3:0]       pk_be;
  logic [LEN_W-1:0] pk_len;
  logic             miss_inc;
  logic [31:0]      status_w;

  assign in_ready  = (state == S_DATA) || (state == S_DROP);
  assign pk_start  = (state == S_BUF_CAP);
  assign pk_accept = (state == S_DATA) && in_valid;
  assign miss_inc  = (state == S_ST_CAP) && !mem_rdata[B_OWN];
  assign status_w  = wb_word(eor_q, pk_long, runt_q, crc_q, pk_len);

  rxring_packer u_pack (
    .clk(clk), .rst(rst), .start(pk_start), .accept(pk_accept),
    .in_byte(in_data), .last(in_last), .buf_base(buf_q), .buf_size(size_q),
    .emit(pk_emit), .emit_addr(pk_addr), .emit_data(pk_data), .emit_be(pk_be),
    .len_field(pk_len), .too_long(pk_long)
  );

  rxring_ptr u_ptr (
    .clk(clk), .rst(rst), .base_we(base_we), .ring_base_hi(ring_base_hi),
    .advance(state == S_WB), .wrap(eor_q), .cur_desc(cur_desc)
  );

  rxring_miss_ctr #(.MISS_W(MISS_W)) u_miss (
    .clk(clk), .rst(rst), .inc(miss_inc), .clr(missed_clr), .count(missed_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      rx_event  <= '0;
      eor_q     <= 1'b0;
      crc_q     <= 1'b0;
      runt_q    <= 1'b0;
      size_q    <= '0;
      buf_q     <= '0;
    end else begin
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      rx_event <= '0;
      case (state)
        S_IDLE: if (in_valid) begin
          mem_req  <= 1'b1;
          mem_addr <= cur_desc;
          mem_be   <= 4'hF;
          state    <= S_ST_REQ;
        end
        S_ST_REQ: state <= S_ST_CAP;
        S_ST_CAP: begin
          if (mem_rdata[B_OWN]) begin
            eor_q    <= mem_rdata[B_EOR];
            size_q   <= mem_rdata[LEN_W-1:0];
            mem_req  <= 1'b1;
            mem_addr <= cur_desc + 32'(BUFPTR_OFF);
            mem_be   <= 4'hF;
            state    <= S_BUF_REQ;
          end else begin
            state <= S_DROP;
          end
        end
        S_BUF_REQ: state <= S_BUF_CAP;
        S_BUF_CAP: begin
          buf_q <= mem_rdata;
          state <= S_DATA;
        end
        S_DATA: begin
          if (pk_emit) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= pk_addr;
            mem_be    <= pk_be;
            mem_wdata <= pk_data;
          end
          if (in_valid && in_last) begin
            crc_q  <= in_crc_err;
            runt_q <= in_runt;
            state  <= S_WB;
          end
        end
        S_WB: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur_desc;
          mem_be    <= 4'hF;
          mem_wdata <= status_w;
          rx_event  <= status_w[B_SUM] ? 2'b10 : 2'b01;
          state     <= S_IDLE;
        end
        S_DROP: if (in_valid && in_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r10_event_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_event));
  a_r8_quiet_drop: assert property (@(posedge clk) disable iff (rst)
    (state == S_DROP) |-> !mem_req);
endmodule

// File: tb/tb_rxring_writer.sv
module tb_rxring_writer;
  localparam int MW  = 3;
  localparam int CAP = 22;

  logic clk = 0, rst = 1;
  logic base_we = 0;
  logic [23:0] ring_base_hi = '0;
  logic in_valid = 0, in_last = 0, in_crc_err = 0, in_runt = 0;
  logic [7:0] in_data = '0;
  logic in_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [3:0] mem_be;
  logic missed_clr = 0;
  logic [MW-1:0] missed_count;
  logic [1:0] rx_event;

  logic [31:0] mem [0:1023];
  logic tb_wr = 0;
  logic [31:0] tb_addr = '0, tb_val = '0;
  int wr_count = 0;
  logic [31:0] last_wr = '0;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  rxring_writer #(.MISS_W(MW)) dut (
    .clk(clk), .rst(rst), .base_we(base_we), .ring_base_hi(ring_base_hi),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_crc_err(in_crc_err), .in_runt(in_runt), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .missed_clr(missed_clr),
    .missed_count(missed_count), .rx_event(rx_event)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        wr_count <= wr_count + 1;
        last_wr  <= mem_addr;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
    if (tb_wr) mem[tb_addr[11:2]] <= tb_val;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wmem(input logic [31:0] a, input logic [31:0] v);
    tb_addr = a; tb_val = v; tb_wr = 1;
    @(negedge clk);
    tb_wr = 0;
  endtask

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  function automatic logic [7:0] pat(input int n, input int i);
    return 8'((n * 7 + i * 13) & 255);
  endfunction

  task automatic send(input int n, input logic crc, input logic runt);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = pat(n, i); in_last = (i == n - 1);
      in_crc_err = crc; in_runt = runt;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 0; in_last = 0; in_crc_err = 0; in_runt = 0;
  endtask

  task automatic wait_event(output logic [1:0] ev);
    ev = '0;
    for (int k = 0; k < 60; k++) begin
      if (rx_event != 0) begin ev = rx_event; break; end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] d, input logic [31:0] bufa, input logic eor);
    for (int w = 0; w < 16; w++) wmem(bufa + 32'(4 * w), 32'hA5A5A5A5);
    wmem(d + 8, bufa);
    wmem(d, {1'b1, eor, 17'b0, 13'(CAP)});
  endtask

  task automatic frame_check(input logic [31:0] d, input logic [31:0] bufa, input logic eor,
                             input int n, input logic crc, input logic runt);
    logic [1:0] ev;
    int stored, bad;
    logic tl, sum;
    logic [31:0] exp;
    send(n, crc, runt);
    wait_event(ev);
    stored = (n > CAP) ? CAP : n;
    tl  = n > CAP;
    sum = tl | crc | runt;
    exp = {1'b0, eor, 2'b11, 5'b0, tl, sum, runt, crc, 6'b0, 13'(stored)};
    check("R3/R4/R5 status", mem[d[11:2]], exp);
    check("R10 event", {30'b0, ev}, sum ? 32'd2 : 32'd1);
    check("R11 last write is status", last_wr, d);
    bad = 0;
    for (int i = 0; i < 64; i++)
      if (rd_byte(bufa + 32'(i)) !== ((i < stored) ? pat(n, i) : 8'hA5)) bad++;
    check("R2/R5 buffer bytes", 32'(bad), 0);
  endtask

  initial begin
    logic [31:0] d, bufa;
    int ri, wc;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    check("R1 in_ready", {31'b0, in_ready}, 0);
    check("R1 mem_req", {31'b0, mem_req}, 0);
    check("R1 missed", 32'(missed_count), 0);
    check("R1 event", {30'b0, rx_event}, 0);
    rst = 0;
    @(negedge clk);
    ring_base_hi = 24'h000001; base_we = 1;
    @(negedge clk);
    base_we = 0;
    ri = 0;
    for (int n = 1; n <= 26; n++) begin
      d    = 32'h100 + 32'(16 * ri);
      bufa = 32'h400 + 32'(64 * ri);
      arm(d, bufa, ri == 3);
      frame_check(d, bufa, ri == 3, n, (n % 3) == 0, (n % 5) == 0);
      ri = (ri + 1) % 4;
    end
    // R8 / R9: software-owned descriptor, drops saturate the counter
    d = 32'h100 + 32'(16 * ri);
    bufa = 32'h400 + 32'(64 * ri);
    wmem(d, 32'h0);
    wc = wr_count;
    for (int k = 1; k <= 9; k++) begin
      send(5, 0, 0);
      repeat (3) @(negedge clk);
      check("R8 R9 missed count", 32'(missed_count), (k < 7) ? 32'(k) : 32'd7);
    end
    check("R8 no writes on drop", 32'(wr_count), 32'(wc));
    check("R8 status untouched", mem[d[11:2]], 32'h0);
    missed_clr = 1;
    @(negedge clk);
    missed_clr = 0;
    check("R9 clear", 32'(missed_count), 0);
    arm(d, bufa, ri == 3);
    frame_check(d, bufa, ri == 3, 8, 0, 0);
    // R6 / R7: single-descriptor ring after base reload
    ring_base_hi = 24'h000002; base_we = 1;
    @(negedge clk);
    base_we = 0;
    for (int k = 0; k < 2; k++) begin
      arm(32'h200, 32'h800, 1'b1);
      frame_check(32'h200, 32'h800, 1'b1, 9 + k, 0, k == 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule